// File: doc/BRIEF.md
# Two-level interrupt status and mask unit

This block collects three event flags raised by a random-number core (a completion flag, a health-test fault flag and a certification fault flag) and turns them into one level interrupt. At the first level, each flag is qualified by its own enable bit. The OR of the enabled flags forms a core interrupt bit. At the second level, that core bit sits in a top status register next to a bus-error bit. The top status is gated by a mask to drive `irq`.

Software drives a simple register strobe interface: a word address, a data word and a write strobe, with a combinational read port. The mask cannot be written directly. Software changes it by writing ones to a separate unmask register or a separate do-mask register, and both of these read back as zero. Each first-level flag is cleared by its own clear bit in the event control register.

Fault injection is qualified by the state of the random-number core. Fault pulses are accepted only when the core is out of reset and both its oscillator and its entropy source are enabled. On a core whose revision is older than 0x0200, a certification fault is also accepted only while the certification checker is enabled.

Top module: `evt_irq_unit`

Register word addresses are: 0 event control, 1 event status, 2 top status, 3 mask, 4 unmask, 5 do-mask. Addresses 6 and 7 are unmapped.

## Requirements
- R1: After reset, the enables, the event flags and the top status read as 0, the mask reads 0x3, and `irq` is low.
- R2: At address 0, bits 2:0 are the enables for done (bit 0), health fault (bit 1) and cert fault (bit 2). They are written and read back there. Bits 5:3 are clear strobes and read as 0.
- R3: At address 1, done is bit 0, health fault is bit 1 and cert fault is bit 3. Each flag is set one cycle after its set pulse is accepted, and a done pulse is always accepted.
- R4: A health-fault or cert-fault pulse is ignored unless `gen_in_reset` is 0, `src_en` is 1 and `osc_en` is 1.
- R5: When `HW_REV` < 0x0200, a cert-fault pulse is also ignored while `cert_chk_en` is 0.
- R6: Writing address 0 with bit 3, 4 or 5 set clears done, health or cert respectively. A set pulse arriving in the same cycle wins over the clear.
- R7: The top status bit 0 (core bit) becomes OR(flag AND enable) one cycle after any accepted set pulse or any write to address 0. This re-evaluation wins over a same-cycle clear of the bit.
- R8: Top status (address 2) is write-one-to-clear on bits 1:0. Bit 1 is set by `bus_err_set`, and the set wins over a same-cycle clear.
- R9: The mask (address 3) ignores direct writes. Writing ones to address 4 clears the corresponding mask bits, and writing ones to address 5 sets them. Addresses 4 and 5 read as 0.
- R10: `irq` is high exactly when some top status bit is set and its mask bit is clear.
- R11: Addresses 6 and 7 read as 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write word address |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Read word address |
| rd_data | output | DATA_W | Combinational read data |
| done_set | input | 1 | Completion event pulse |
| health_fault_set | input | 1 | Health-test fault pulse |
| cert_fault_set | input | 1 | Certification fault pulse |
| bus_err_set | input | 1 | Bus error event pulse |
| gen_in_reset | input | 1 | Random-number core is held in reset |
| src_en | input | 1 | Entropy source enabled |
| osc_en | input | 1 | Oscillator enabled |
| cert_chk_en | input | 1 | Certification checker enabled (older revisions only) |
| irq | output | 1 | Level interrupt |

## Verification
Every state bit in the block can be read back through the read port. A wrong flag, enable, core bit or mask bit therefore shows up at the read port one clock after the cycle that corrupted it. If the bit is also unmasked, it shows up on `irq` in that same cycle.

A dropped or spurious re-evaluation of the core bit shows up as a top status that disagrees with the flags ANDed with the enables. A gating error in fault acceptance shows up as a flag appearing, or failing to appear, at address 1.

Two instances, at the current and at an older revision, are driven with identical stimulus. This exposes any difference in how cert faults are qualified.

// File: rtl/evt_irq_unit.sv
module evt_irq_unit #(
  parameter int          DATA_W = 32,
  parameter int          ADDR_W = 3,
  parameter logic [15:0] HW_REV = 16'h0200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              done_set,
  input  logic              health_fault_set,
  input  logic              cert_fault_set,
  input  logic              bus_err_set,
  input  logic              gen_in_reset,
  input  logic              src_en,
  input  logic              osc_en,
  input  logic              cert_chk_en,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_EVCTL  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_EVSTAT = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_TOP    = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_MASK   = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_UNMASK = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_DOMASK = ADDR_W'(5);
  localparam bit OLD_REV = HW_REV < 16'h0200;

  logic [2:0] en_q, flg_q, en_d, flg_d, flg_set, flg_clr;
  logic       core_q, bus_q, core_d, bus_d;
  logic [1:0] mask_q, mask_d;
  logic       unused_hi;

  wire ctl_wr   = wr_en && (wr_addr == A_EVCTL);
  wire top_wr   = wr_en && (wr_addr == A_TOP);
  wire unm_wr   = wr_en && (wr_addr == A_UNMASK);
  wire dom_wr   = wr_en && (wr_addr == A_DOMASK);
  wire fault_ok = !gen_in_reset && src_en && osc_en;
  wire cert_ok  = fault_ok && (!OLD_REV || cert_chk_en);
  wire h_acc    = health_fault_set && fault_ok;
  wire c_acc    = cert_fault_set && cert_ok;
  wire reeval   = ctl_wr || done_set || h_acc || c_acc;

  assign unused_hi = ^wr_data[DATA_W-1:6];

  assign flg_set = {c_acc, h_acc, done_set};
  assign flg_clr = ctl_wr ? wr_data[5:3] : 3'b000;
  assign en_d    = ctl_wr ? wr_data[2:0] : en_q;
  assign flg_d   = flg_set | (flg_q & ~flg_clr);
  assign core_d  = reeval ? |(flg_d & en_d) : (core_q && !(top_wr && wr_data[0]));
  assign bus_d   = bus_err_set || (bus_q && !(top_wr && wr_data[1]));
  assign mask_d  = unm_wr ? (mask_q & ~wr_data[1:0])
                 : dom_wr ? (mask_q | wr_data[1:0]) : mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      flg_q  <= '0;
      core_q <= 1'b0;
      bus_q  <= 1'b0;
      mask_q <= 2'b11;
    end else begin
      en_q   <= en_d;
      flg_q  <= flg_d;
      core_q <= core_d;
      bus_q  <= bus_d;
      mask_q <= mask_d;
    end
  end

  assign irq = |({bus_q, core_q} & ~mask_q);

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_EVCTL:  rd_data[2:0] = en_q;
      A_EVSTAT: begin
        rd_data[0] = flg_q[0];
        rd_data[1] = flg_q[1];
        rd_data[3] = flg_q[2];
      end
      A_TOP:    rd_data[1:0] = {bus_q, core_q};
      A_MASK:   rd_data[1:0] = mask_q;
      default:  rd_data = '0;
    endcase
  end

  p_health_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((gen_in_reset || !src_en || !osc_en) && !flg_q[1]) |=> !flg_q[1]);

  p_clear_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && wr_data[3] && !done_set) |=> !flg_q[0]);

  p_core_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> (core_q == |(flg_q & en_q)));

  p_mask_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(unm_wr || dom_wr) |=> $stable(mask_q));

  p_masked_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == 2'b11) |-> !irq);

  p_bus_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err_set |=> bus_q);

  if (OLD_REV) begin : g_old_rev
    p_cert_chk_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!cert_chk_en && !flg_q[2]) |=> !flg_q[2]);
  end
endmodule

// File: tb/evt_irq_unit_test.sv
`timescale 1ns/1ps
module evt_irq_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_new, rd_old;
  logic        ev_d = 0, ev_h = 0, ev_c = 0, ev_b = 0;
  logic        inrst = 0, src = 1, osc = 1, chk = 0;
  logic        irq_new, irq_old;

  logic [2:0] m_en [2];
  logic [2:0] m_flg [2];
  logic       m_core [2];
  logic       m_bus [2];
  logic [1:0] m_mask [2];
  int checks = 0, errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  evt_irq_unit uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_new), .done_set(ev_d), .health_fault_set(ev_h),
    .cert_fault_set(ev_c), .bus_err_set(ev_b), .gen_in_reset(inrst), .src_en(src),
    .osc_en(osc), .cert_chk_en(chk), .irq(irq_new));

  evt_irq_unit #(.HW_REV(16'h0100)) uut_old (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_old), .done_set(ev_d), .health_fault_set(ev_h),
    .cert_fault_set(ev_c), .bus_err_set(ev_b), .gen_in_reset(inrst), .src_en(src),
    .osc_en(osc), .cert_chk_en(chk), .irq(irq_old));

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(int i, int a);
    logic [31:0] v = '0;
    case (a)
      0: v[2:0] = m_en[i];
      1: begin v[0] = m_flg[i][0]; v[1] = m_flg[i][1]; v[3] = m_flg[i][2]; end
      2: v[1:0] = {m_bus[i], m_core[i]};
      3: v[1:0] = m_mask[i];
      default: v = '0;
    endcase
    return v;
  endfunction

  function automatic string req_of(int a);
    case (a)
      0: return "R2";
      1: return "R3";
      2: return "R8";
      3, 4, 5: return "R9";
      default: return "R11";
    endcase
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 2; i++) begin
      m_en[i] = '0; m_flg[i] = '0; m_core[i] = 0; m_bus[i] = 0; m_mask[i] = 2'b11;
    end
  endtask

  task automatic model_step();
    for (int i = 0; i < 2; i++) begin
      logic gate, cok, cw, tw, h, c, re;
      logic [2:0] en_n, flg_n;
      gate = !inrst && src && osc;
      cok  = gate && ((i == 0) || chk);
      cw   = wr_en && wr_addr == 3'd0;
      tw   = wr_en && wr_addr == 3'd2;
      h    = ev_h && gate;
      c    = ev_c && cok;
      re   = cw || ev_d || h || c;
      en_n = cw ? wr_data[2:0] : m_en[i];
      flg_n[0] = ev_d || (m_flg[i][0] && !(cw && wr_data[3]));
      flg_n[1] = h    || (m_flg[i][1] && !(cw && wr_data[4]));
      flg_n[2] = c    || (m_flg[i][2] && !(cw && wr_data[5]));
      if (re) m_core[i] = |(flg_n & en_n);
      else if (tw && wr_data[0]) m_core[i] = 0;
      m_bus[i] = ev_b || (m_bus[i] && !(tw && wr_data[1]));
      if (wr_en && wr_addr == 3'd4) m_mask[i] = m_mask[i] & ~wr_data[1:0];
      if (wr_en && wr_addr == 3'd5) m_mask[i] = m_mask[i] | wr_data[1:0];
      m_en[i] = en_n; m_flg[i] = flg_n;
    end
  endtask

  task automatic rd(int i, int a, output logic [31:0] v);
    rd_addr = 3'(a);
    #0.1;
    v = (i == 0) ? rd_new : rd_old;
  endtask

  task automatic check_all();
    logic [31:0] v;
    for (int i = 0; i < 2; i++) begin
      for (int a = 0; a < 8; a++) begin
        rd(i, a, v);
        check(req_of(a), $sformatf("inst%0d addr%0d", i, a), v, exp_read(i, a));
      end
      check("R10", $sformatf("inst%0d irq", i), {31'b0, (i == 0) ? irq_new : irq_old},
            {31'b0, |({m_bus[i], m_core[i]} & ~m_mask[i])});
    end
  endtask

  task automatic step(logic we, logic [2:0] a, logic [31:0] d,
                      logic d_ev, logic h_ev, logic c_ev, logic b_ev);
    wr_en = we; wr_addr = a; wr_data = d;
    ev_d = d_ev; ev_h = h_ev; ev_c = c_ev; ev_b = b_ev;
    model_step();
    @(posedge clk);
    @(negedge clk);
    wr_en = 0; ev_d = 0; ev_h = 0; ev_c = 0; ev_b = 0;
    check_all();
  endtask

  initial begin
    #800000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'h5eed1234));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(0, 3, v); check("R1", "mask after reset", v, 32'h3);
    rd(0, 1, v); check("R1", "flags after reset", v, 32'h0);
    check("R1", "irq after reset", {31'b0, irq_new}, 32'h0);
    check_all();

    // R4 gating of health faults
    inrst = 1; step(0, 0, 0, 0, 1, 0, 0);
    rd(0, 1, v); check("R4", "health in core reset", v, 32'h0);
    inrst = 0; src = 0; step(0, 0, 0, 0, 1, 0, 0);
    rd(0, 1, v); check("R4", "health with source off", v, 32'h0);
    src = 1; osc = 0; step(0, 0, 0, 0, 1, 1, 0);
    rd(0, 1, v); check("R4", "faults with oscillator off", v, 32'h0);
    osc = 1;

    // R5 older revision cert qualification
    step(0, 0, 0, 0, 0, 1, 0);
    rd(0, 1, v); check("R3", "cert flag bit3", v, 32'h8);
    rd(1, 1, v); check("R5", "old rev cert blocked", v, 32'h0);
    chk = 1; step(0, 0, 0, 0, 0, 1, 0);
    rd(1, 1, v); check("R5", "old rev cert accepted", v, 32'h8);
    chk = 0;

    step(0, 0, 0, 0, 1, 0, 0);
    step(0, 0, 0, 1, 0, 0, 0);
    rd(0, 1, v); check("R3", "all flags", v, 32'hB);

    // R6 clear with same-cycle set
    step(1, 0, 32'h38, 1, 0, 0, 0);
    rd(0, 1, v); check("R6", "set wins over clear", v, 32'h1);
    rd(0, 0, v); check("R2", "clear bits read zero", v, 32'h0);

    // R7 core bit re-evaluated on enable write
    step(1, 0, 32'h1, 0, 0, 0, 0);
    rd(0, 2, v); check("R7", "core after enable", v, 32'h1);
    check("R10", "masked irq", {31'b0, irq_new}, 32'h0);

    // R9 unmask
    step(1, 4, 32'h1, 0, 0, 0, 0);
    rd(0, 3, v); check("R9", "mask after unmask", v, 32'h2);
    rd(0, 4, v); check("R9", "unmask reads zero", v, 32'h0);
    check("R10", "irq unmasked", {31'b0, irq_new}, 32'h1);
    step(1, 3, 32'h3, 0, 0, 0, 0);
    rd(0, 3, v); check("R9", "direct mask write ignored", v, 32'h2);

    // R8 W1C of core bit
    step(1, 2, 32'h1, 0, 0, 0, 0);
    rd(0, 2, v); check("R8", "core cleared", v, 32'h0);
    check("R10", "irq after clear", {31'b0, irq_new}, 32'h0);
    step(1, 2, 32'h1, 1, 0, 0, 0);
    rd(0, 2, v); check("R7", "reeval wins over clear", v, 32'h1);
    step(1, 2, 32'h2, 0, 0, 0, 1);
    rd(0, 2, v); check("R8", "bus set wins", v, 32'h3);
    step(1, 5, 32'h3, 0, 0, 0, 0);
    check("R9", "irq after do-mask", {31'b0, irq_new}, 32'h0);
    step(1, 6, 32'hFFFF_FFFF, 0, 0, 0, 0);
    rd(0, 6, v); check("R11", "unmapped reads zero", v, 32'h0);
    rd(0, 3, v); check("R11", "unmapped write no effect", v, 32'h3);

    for (int n = 0; n < 3000; n++) begin
      inrst = ($urandom % 8) == 0;
      src   = ($urandom % 8) != 0;
      osc   = ($urandom % 8) != 0;
      chk   = $urandom % 2;
      step(($urandom % 5) < 2, 3'($urandom), $urandom,
           ($urandom % 4) == 0, ($urandom % 4) == 0,
           ($urandom % 4) == 0, ($urandom % 6) == 0);
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule